// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits in the receive path of an Ethernet controller and decides whether the frame now arriving is kept. The first six bytes of each frame (the destination address) enter one per cycle on a byte strobe. Each byte is compared on the fly with a six-byte station address held in host-writable registers. The block also tracks whether the address is broadcast or multicast. After the sixth byte, a one-cycle strobe reports whether the address passes the current reception mode.

When the frame ends, a second strobe carries the byte length and a flag from upstream marking the frame as a special reset-type frame. One cycle later the block issues its final verdict. The verdict combines the address result with two length and type rules that the host can relax: frames shorter than 64 bytes are rejected, and reset-type frames are rejected. A runt flag is reported with every verdict.

Top module: `rx_dest_filter`

## Requirements
- R1: After synchronous reset, `addr_done` and `dec_valid` are low, the mode register is 0 and the station address is all zero, so a frame ending after reset without any register write is rejected.
- R2: Mode register bits [1:0] select reception. 0 accepts no address. 1 accepts the own station address and broadcast. 2 also accepts multicast. 3 accepts every address.
- R3: A broadcast address is six bytes all equal to 0xFF. An address with five 0xFF bytes followed by 0xFE is not broadcast.
- R4: A multicast address has bit 0 of the first received destination byte set. It is accepted only in modes 2 and 3.
- R5: Own-address match compares received byte k with station register k (k = 0 first received). When mode bit 4 is set, received byte 5 is left out of the comparison.
- R6: `addr_done` pulses for exactly one cycle, in the cycle after the sixth destination byte is taken, with the address verdict on `addr_ok`. Further bytes before frame end are ignored.
- R7: At frame end, a length below 64 sets `dec_runt`, and such a frame is rejected unless mode bit 3 is set. A length of exactly 64 is not a runt.
- R8: A frame ending with `fe_rst` high is rejected unless mode bit 2 is set. When bit 2 is set, it follows the normal rules.
- R9: `dec_valid` is a one-cycle pulse in the cycle after `fe_valid`. A frame ending before six address bytes were taken is rejected. Frame end restarts byte counting for the next frame, and a byte strobed in the same cycle as `fe_valid` is dropped.
- R10: Host writes at offset 0x0 load the mode register from `reg_wdata[4:0]`. Writes at offsets 0x8 to 0xD load station bytes 0 to 5. A rewritten station address takes effect for the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Host register write strobe |
| reg_addr | input | REG_AW | Host register offset |
| reg_wdata | input | 8 | Host write data |
| da_valid | input | 1 | Destination byte strobe |
| da_byte | input | 8 | Destination byte, first received first |
| fe_valid | input | 1 | Frame-end strobe |
| fe_len | input | LEN_W | Frame length in bytes, valid with `fe_valid` |
| fe_rst | input | 1 | Frame is a reset-type frame, valid with `fe_valid` |
| addr_done | output | 1 | Address verdict strobe |
| addr_ok | output | 1 | Address passes the mode, valid with `addr_done` |
| dec_valid | output | 1 | Final verdict strobe |
| dec_accept | output | 1 | Frame accepted, valid with `dec_valid` |
| dec_runt | output | 1 | Frame shorter than 64 bytes, valid with `dec_valid` |

## Verification
The hardest behaviours to reach from the ports involve the address byte counter, not the comparison. These are surplus bytes after the sixth one, and frames that end before the address is complete. In both cases the counter must stop or restart without leaking state into the next frame. The stimulus reaches them with directed sequences: a full address followed by extra bytes, then a four-byte frame followed at once by a complete frame. The bench then checks the single `addr_done` pulse and the fresh verdict of the following frame. The 5-byte match mode is covered by two addresses, one differing only in the last byte and one differing in the byte before it.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int NUM_ADDR_BYTES = 6;
    localparam int RUNT_LEN       = 64;
    localparam int BYTE_W         = 8;
    localparam int IDX_W          = $clog2(NUM_ADDR_BYTES + 1);
    localparam int CFG_W          = 5;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        RXM_OFF    = 2'd0,
        RXM_UNI_BC = 2'd1,
        RXM_MCAST  = 2'd2,
        RXM_ALL    = 2'd3
    } rx_mode_e;

    // bit 4: five-byte match, bit 3: runt enable, bit 2: reset-type enable
    typedef struct packed {
        logic     five_byte;
        logic     runt_en;
        logic     special_en;
        rx_mode_e mode;
    } rxf_cfg_t;

    typedef struct packed {
        logic own;
        logic bcast;
        logic mcast;
    } addr_class_t;

    function automatic logic mode_admits(rx_mode_e m, addr_class_t c);
        logic r;
        case (m)
            RXM_OFF:    r = 1'b0;
            RXM_UNI_BC: r = c.own | c.bcast;
            RXM_MCAST:  r = c.own | c.bcast | c.mcast;
            default:    r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rxf_regs.sv
module rxf_regs
    import rxf_pkg::*;
#(
    parameter int REG_AW   = 4,
    parameter int MODE_OFS = 0,
    parameter int STA_BASE = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         reg_we,
    input  logic [REG_AW-1:0]            reg_addr,
    input  byte_t                        reg_wdata,
    output rxf_cfg_t                     cfg,
    output byte_t [NUM_ADDR_BYTES-1:0]   sta
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (reg_we && reg_addr == REG_AW'(MODE_OFS)) begin
            cfg <= rxf_cfg_t'(reg_wdata[CFG_W-1:0]);
        end
    end

    for (genvar g = 0; g < NUM_ADDR_BYTES; g++) begin : g_sta
        localparam int OFS = STA_BASE + g;
        always_ff @(posedge clk) begin
            if (rst) begin
                sta[g] <= '0;
            end else if (reg_we && reg_addr == REG_AW'(OFS)) begin
                sta[g] <= reg_wdata;
            end
        end
    end

endmodule

// File: rtl/rxf_addr_cmp.sv
module rxf_addr_cmp
    import rxf_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  rxf_cfg_t                   cfg,
    input  byte_t [NUM_ADDR_BYTES-1:0] sta,
    input  logic                       da_valid,
    input  byte_t                      da_byte,
    input  logic                       fe_valid,
    output logic                       addr_done,
    output logic                       addr_ok,
    output logic                       addr_pass
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ADDR_BYTES - 1);
    localparam logic [IDX_W-1:0] FULL_IDX = IDX_W'(NUM_ADDR_BYTES);

    logic [IDX_W-1:0] idx_q;
    addr_class_t      cls_q, cls_nx;
    byte_t            cur_sta;
    logic             take, own_hit, last_byte;

    always_comb begin
        cur_sta = '0;
        for (int i = 0; i < NUM_ADDR_BYTES; i++) begin
            if (idx_q == IDX_W'(i)) cur_sta = sta[i];
        end
    end

    assign take      = da_valid && !fe_valid && (idx_q < FULL_IDX);
    assign last_byte = (idx_q == LAST_IDX);
    assign own_hit   = (da_byte == cur_sta) || (cfg.five_byte && last_byte);

    always_comb begin
        cls_nx.own   = cls_q.own & own_hit;
        cls_nx.bcast = cls_q.bcast & (da_byte == 8'hFF);
        cls_nx.mcast = (idx_q == '0) ? da_byte[0] : cls_q.mcast;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q     <= '0;
            cls_q     <= '{own: 1'b1, bcast: 1'b1, mcast: 1'b0};
            addr_done <= 1'b0;
            addr_ok   <= 1'b0;
            addr_pass <= 1'b0;
        end else begin
            addr_done <= 1'b0;
            if (fe_valid) begin
                idx_q     <= '0;
                cls_q     <= '{own: 1'b1, bcast: 1'b1, mcast: 1'b0};
                addr_pass <= 1'b0;
            end else if (take) begin
                idx_q <= idx_q + 1'b1;
                cls_q <= cls_nx;
                if (last_byte) begin
                    addr_done <= 1'b1;
                    addr_ok   <= mode_admits(cfg.mode, cls_nx);
                    addr_pass <= mode_admits(cfg.mode, cls_nx);
                end
            end
        end
    end

    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
        idx_q <= FULL_IDX); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        addr_done |=> !addr_done); // R6
    AST_MODE_OFF_NONE: assert property (@(posedge clk) disable iff (rst)
        (take && last_byte && cfg.mode == RXM_OFF) |=> !addr_ok); // R2
    AST_PASS_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(addr_pass) |-> addr_done); // R9

endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
    import rxf_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  rxf_cfg_t         cfg,
    input  logic             addr_pass,
    input  logic             fe_valid,
    input  logic [LEN_W-1:0] fe_len,
    input  logic             fe_rst,
    output logic             dec_valid,
    output logic             dec_accept,
    output logic             dec_runt
);

    localparam logic [LEN_W-1:0] RUNT_LIM = LEN_W'(RUNT_LEN);

    logic is_runt, runt_block, special_block;

    assign is_runt       = fe_len < RUNT_LIM;
    assign runt_block    = is_runt && !cfg.runt_en;
    assign special_block = fe_rst && !cfg.special_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
            dec_runt   <= 1'b0;
        end else if (fe_valid) begin
            dec_valid  <= 1'b1;
            dec_accept <= addr_pass && !runt_block && !special_block;
            dec_runt   <= is_runt;
        end else begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
            dec_runt   <= 1'b0;
        end
    end

    AST_DEC_AFTER_END: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> $past(fe_valid)); // R9
    AST_RUNT_GATED: assert property (@(posedge clk) disable iff (rst)
        (fe_valid && fe_len < RUNT_LIM && !cfg.runt_en) |=> !dec_accept); // R7
    AST_SPECIAL_GATED: assert property (@(posedge clk) disable iff (rst)
        (fe_valid && fe_rst && !cfg.special_en) |=> !dec_accept); // R8
    AST_ACCEPT_NEEDS_ADDR: assert property (@(posedge clk) disable iff (rst)
        (fe_valid && !addr_pass) |=> !dec_accept); // R9

endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
    import rxf_pkg::*;
#(
    parameter int REG_AW   = 4,
    parameter int LEN_W    = 11,
    parameter int MODE_OFS = 0,
    parameter int STA_BASE = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              da_valid,
    input  logic [7:0]        da_byte,
    input  logic              fe_valid,
    input  logic [LEN_W-1:0]  fe_len,
    input  logic              fe_rst,
    output logic              addr_done,
    output logic              addr_ok,
    output logic              dec_valid,
    output logic              dec_accept,
    output logic              dec_runt
);

    rxf_cfg_t                   cfg;
    byte_t [NUM_ADDR_BYTES-1:0] sta;
    logic                       addr_pass;

    rxf_regs #(
        .REG_AW   (REG_AW),
        .MODE_OFS (MODE_OFS),
        .STA_BASE (STA_BASE)
    ) regs_i (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .cfg       (cfg),
        .sta       (sta)
    );

    rxf_addr_cmp cmp_i (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .sta       (sta),
        .da_valid  (da_valid),
        .da_byte   (da_byte),
        .fe_valid  (fe_valid),
        .addr_done (addr_done),
        .addr_ok   (addr_ok),
        .addr_pass (addr_pass)
    );

    rxf_decide #(
        .LEN_W (LEN_W)
    ) dec_i (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg),
        .addr_pass  (addr_pass),
        .fe_valid   (fe_valid),
        .fe_len     (fe_len),
        .fe_rst     (fe_rst),
        .dec_valid  (dec_valid),
        .dec_accept (dec_accept),
        .dec_runt   (dec_runt)
    );

endmodule

// File: tb/rx_dest_filter_tb_top.sv
module rx_dest_filter_tb_top;

    localparam int LEN_W = 11;
    localparam logic [47:0] STA = 48'h02_11_22_33_44_55;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             reg_we = 1'b0;
    logic [3:0]       reg_addr = '0;
    logic [7:0]       reg_wdata = '0;
    logic             da_valid = 1'b0;
    logic [7:0]       da_byte = '0;
    logic             fe_valid = 1'b0;
    logic [LEN_W-1:0] fe_len = '0;
    logic             fe_rst = 1'b0;
    logic             addr_done, addr_ok, dec_valid, dec_accept, dec_runt;

    int n_run  = 0;
    int n_fail = 0;
    logic got_done, got_ok, got_dv, got_acc, got_runt;

    always #10 clk = ~clk;

    rx_dest_filter dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .da_valid(da_valid), .da_byte(da_byte),
        .fe_valid(fe_valid), .fe_len(fe_len), .fe_rst(fe_rst),
        .addr_done(addr_done), .addr_ok(addr_ok), .dec_valid(dec_valid),
        .dec_accept(dec_accept), .dec_runt(dec_runt)
    );

    typedef struct packed {
        logic [7:0]       mode;
        logic [47:0]      dst;
        logic [LEN_W-1:0] len;
        logic             special;
        logic             ok;
        logic             acc;
        logic             runt;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VT [NV] = '{
        '{8'h01, STA,                 11'd100, 1'b0, 1'b1, 1'b1, 1'b0}, // R5 own
        '{8'h01, 48'hFFFFFFFFFFFF,    11'd100, 1'b0, 1'b1, 1'b1, 1'b0}, // R3 bcast
        '{8'h01, 48'h01005E000001,    11'd100, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 mcast mode1
        '{8'h02, 48'h01005E000001,    11'd100, 1'b0, 1'b1, 1'b1, 1'b0}, // R4 mcast mode2
        '{8'h02, 48'h001122334455,    11'd100, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 other mode2
        '{8'h03, 48'h001122334455,    11'd100, 1'b0, 1'b1, 1'b1, 1'b0}, // R2 promisc
        '{8'h00, STA,                 11'd100, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 off
        '{8'h00, 48'hFFFFFFFFFFFF,    11'd100, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 off bcast
        '{8'h01, 48'h021122334466,    11'd100, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 last differs
        '{8'h11, 48'h021122334466,    11'd100, 1'b0, 1'b1, 1'b1, 1'b0}, // R5 five-byte
        '{8'h11, 48'h021122334555,    11'd100, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 five-byte miss
        '{8'h01, 48'hFFFFFFFFFFFE,    11'd100, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 not bcast
        '{8'h01, STA,                 11'd63,  1'b0, 1'b1, 1'b0, 1'b1}, // R7 runt
        '{8'h09, STA,                 11'd63,  1'b0, 1'b1, 1'b1, 1'b1}, // R7 runt enabled
        '{8'h01, STA,                 11'd64,  1'b0, 1'b1, 1'b1, 1'b0}, // R7 boundary
        '{8'h01, STA,                 11'd100, 1'b1, 1'b1, 1'b0, 1'b0}  // R8 special blocked
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic send_bytes(input logic [47:0] d, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            da_valid = 1'b1;
            da_byte  = d[47 - 8*i -: 8];
        end
        @(negedge clk);
        da_valid = 1'b0;
        got_done = addr_done;
        got_ok   = addr_ok;
    endtask

    task automatic end_frame(input logic [LEN_W-1:0] l, input logic sp);
        @(negedge clk);
        fe_valid = 1'b1; fe_len = l; fe_rst = sp;
        @(negedge clk);
        fe_valid = 1'b0; fe_rst = 1'b0;
        got_dv   = dec_valid;
        got_acc  = dec_accept;
        got_runt = dec_runt;
    endtask

    task automatic program_sta(input logic [47:0] s);
        for (int i = 0; i < 6; i++) wr_reg(4'(8 + i), s[47 - 8*i -: 8]);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset addr_done", addr_done, 1'b0);
        chk("R1 reset dec_valid", dec_valid, 1'b0);
        send_bytes(48'h000000000000, 6);
        end_frame(11'd100, 1'b0);
        chk("R1 default mode rejects", got_acc, 1'b0);

        program_sta(STA);

        // table walk
        for (int v = 0; v < NV; v++) begin
            wr_reg(4'h0, VT[v].mode);
            send_bytes(VT[v].dst, 6);
            chk($sformatf("R6 addr_done vec %0d", v), got_done, 1'b1);
            chk($sformatf("R2 addr_ok vec %0d", v), got_ok, VT[v].ok);
            end_frame(VT[v].len, VT[v].special);
            chk($sformatf("R9 dec_valid vec %0d", v), got_dv, 1'b1);
            chk($sformatf("R2 dec_accept vec %0d", v), got_acc, VT[v].acc);
            chk($sformatf("R7 dec_runt vec %0d", v), got_runt, VT[v].runt);
        end

        // R8: special frame accepted when enabled
        wr_reg(4'h0, 8'h05);
        send_bytes(STA, 6);
        end_frame(11'd100, 1'b1);
        chk("R8 special enabled accept", got_acc, 1'b1);

        // R6: surplus bytes ignored, single pulse
        wr_reg(4'h0, 8'h01);
        send_bytes(STA, 6);
        chk("R6 done before surplus", got_done, 1'b1);
        send_bytes(48'hDEADBEEF0000, 3);
        chk("R6 no second done", got_done, 1'b0);
        end_frame(11'd100, 1'b0);
        chk("R6 surplus ignored accept", got_acc, 1'b1);

        // R9: short frame rejected, restart, pulse width
        wr_reg(4'h0, 8'h03);
        send_bytes(STA, 4);
        chk("R9 short no done", got_done, 1'b0);
        end_frame(11'd100, 1'b0);
        chk("R9 short frame rejected", got_acc, 1'b0);
        @(negedge clk);
        chk("R9 dec_valid one cycle", dec_valid, 1'b0);
        wr_reg(4'h0, 8'h01);
        send_bytes(STA, 6);
        chk("R9 restart done", got_done, 1'b1);
        chk("R9 restart ok", got_ok, 1'b1);
        end_frame(11'd100, 1'b0);
        chk("R9 restart accept", got_acc, 1'b1);

        // R10: station rewrite takes effect
        program_sta(48'hAABBCCDDEEF0);
        send_bytes(STA, 6);
        chk("R10 old station no match", got_ok, 1'b0);
        end_frame(11'd100, 1'b0);
        send_bytes(48'hAABBCCDDEEF0, 6);
        chk("R10 new station match", got_ok, 1'b1);
        end_frame(11'd100, 1'b0);
        chk("R10 new station accept", got_acc, 1'b1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule